// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block converts rising edges on a bank of interrupt input pins into outbound interrupt messages. Each pin owns a 64-bit table entry. Software programs the entry through an indexed 32-bit register port. The entry holds the interrupt vector, the delivery mode, a destination in physical or logical form, an extended destination ID and a mask bit.

Each pin has a delivery-status bit, and this bit acts as a lock. A rising edge on an unmasked pin sets the bit. While the bit is set, later edges on that pin are ignored. The bit clears only when the message bus acknowledges the message that the pin produced. A fixed priority arbiter, lowest pin index first, chooses which pending pin drives the single message interface. The chosen message is latched and held steady until the acknowledge arrives.

A message carries the vector, the delivery mode and a 32-bit address. The address holds a fixed upper field of FEEh, the destination, the extended destination ID and the destination-mode flag.

Top module: `irq_redirect_ctl`

## Requirements
- R1: After reset, every entry's low half reads 00010000h, which means masked with all other fields 0. Every high half reads 00008000h. No message is valid.
- R2: An index register written through the index port selects a half-entry. Index 10h+2n is the low half of entry n and 11h+2n is its high half, for n from 0 to 23. Indices outside 10h..3Fh read 0, and data writes to them change nothing.
- R3: The low-half layout is as follows. Bits 7:0 hold the vector, bits 10:8 the delivery mode, bit 11 the destination mode (1 = logical), bit 12 the delivery status (read-only) and bit 16 the mask. All other bits read 0 whatever was written.
- R4: The high-half layout is as follows. Bits 31:24 hold the destination and bits 23:16 the extended destination ID. Bit 15 is the delivery-type bit and always reads 1, even after a write of 0. Bits 14:0 read 0.
- R5: A rising edge on an unmasked pin is sampled at a clock edge. At that edge the pin's status bit is set. At the next edge the message becomes valid, provided no other message is in flight and no lower-index pin is pending.
- R6: An edge on a pin whose mask bit is 1 neither sets its status bit nor produces a message.
- R7: While a pin's status bit is set, further edges on that pin are ignored, including an edge in the same cycle as that pin's acknowledge.
- R8: While msg_valid is high and msg_ack is low, msg_valid, msg_vector, msg_mode and msg_addr hold their values.
- R9: msg_addr is built as follows. Bits 31:20 are FEEh. Bits 19:12 hold the destination: all 8 bits in logical mode, or {0000b, destination[3:0]} in physical mode. Bits 11:4 hold the extended destination ID. Bit 2 is the destination mode. All other bits are 0.
- R10: A cycle with msg_valid and msg_ack both high clears the granted pin's status bit and drops msg_valid at the next edge. After that, the pin accepts a new edge.
- R11: When several pins are pending, messages are issued in ascending pin index. A pin that becomes pending while a message is in flight can overtake higher-index pins that were already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 24 | Interrupt input pins, synchronous to clk |
| idx_we | input | 1 | Write strobe for the index register |
| idx_wdata | input | 8 | New index value |
| data_we | input | 1 | Write strobe for the half-entry selected by the index |
| data_wdata | input | 32 | Data for the selected half-entry |
| data_rdata | output | 32 | Contents of the selected half-entry |
| msg_valid | output | 1 | Outbound message request |
| msg_vector | output | 8 | Vector of the granted pin |
| msg_mode | output | 3 | Delivery mode of the granted pin |
| msg_addr | output | 32 | Message address of the granted pin |
| msg_ack | input | 1 | Message bus acknowledge |

## Verification
Two events can fall in the same cycle: the acknowledge that releases a pin's lock, and a fresh rising edge. The edge may be on that same pin or on a lower-index pin. The bench provokes this by raising pin 5 and pin 1 in the exact cycle that pin 5's message is acknowledged. The edge on pin 5 must be lost, because its lock is still held in that cycle. Pin 1 must be issued ahead of the pins 7 and 9 that were already pending. The bench judges the result against the recorded order of acknowledged vectors, and against a behavioural reference model that is compared on every clock.

// File: rtl/irq_redirect_ctl.sv
`timescale 1ns/1ps
module irq_redirect_ctl #(
  parameter int          NUM_PINS = 24,
  parameter logic [7:0]  IDX_BASE = 8'h10,
  parameter logic [11:0] ADDR_TOP = 12'hFEE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                idx_we,
  input  logic [7:0]          idx_wdata,
  input  logic                data_we,
  input  logic [31:0]         data_wdata,
  output logic [31:0]         data_rdata,
  output logic                msg_valid,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_mode,
  output logic [31:0]         msg_addr,
  input  logic                msg_ack
);
  localparam int         PW    = $clog2(NUM_PINS);
  localparam logic [7:0] SPAN8 = 8'(2 * NUM_PINS);

  logic [7:0]          vec_q  [NUM_PINS];
  logic [2:0]          mode_q [NUM_PINS];
  logic [7:0]          dest_q [NUM_PINS];
  logic [7:0]          edid_q [NUM_PINS];
  logic [NUM_PINS-1:0] dmode_q, mask_q, stat_q, irq_q;

  logic [7:0]    idx_q, off;
  logic          hit, half;
  logic [PW-1:0] sel;

  assign off  = idx_q - IDX_BASE;
  assign hit  = (idx_q >= IDX_BASE) && (off < SPAN8);
  assign half = off[0];
  assign sel  = off[PW:1];

  logic unused_wbits;
  assign unused_wbits = ^data_wdata[15:12];

  always_ff @(posedge clk)
    if (!rst_n) idx_q <= '0;
    else if (idx_we) idx_q <= idx_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        vec_q[i]  <= '0;
        mode_q[i] <= '0;
        dest_q[i] <= '0;
        edid_q[i] <= '0;
      end
      dmode_q <= '0;
      mask_q  <= '1;
    end else if (data_we && hit) begin
      if (!half) begin
        vec_q[sel]   <= data_wdata[7:0];
        mode_q[sel]  <= data_wdata[10:8];
        dmode_q[sel] <= data_wdata[11];
        mask_q[sel]  <= data_wdata[16];
      end else begin
        dest_q[sel] <= data_wdata[31:24];
        edid_q[sel] <= data_wdata[23:16];
      end
    end
  end

  always_comb begin
    data_rdata = '0;
    if (hit) begin
      if (!half)
        data_rdata = {15'b0, mask_q[sel], 3'b0, stat_q[sel], dmode_q[sel],
                      mode_q[sel], vec_q[sel]};
      else
        data_rdata = {dest_q[sel], edid_q[sel], 1'b1, 15'b0};
    end
  end

  logic                cur_v;
  logic [PW-1:0]       cur_idx;
  logic [NUM_PINS-1:0] latch_vec, clr_vec;
  logic                pick_any;
  logic [PW-1:0]       pick;

  assign latch_vec = irq_in & ~irq_q & ~mask_q & ~stat_q;
  assign clr_vec   = (cur_v && msg_ack) ? (NUM_PINS'(1) << cur_idx) : '0;

  always_ff @(posedge clk)
    if (!rst_n) begin
      irq_q  <= '0;
      stat_q <= '0;
    end else begin
      irq_q  <= irq_in;
      stat_q <= (stat_q | latch_vec) & ~clr_vec;
    end

  always_comb begin
    pick_any = 1'b0;
    pick     = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (stat_q[i]) begin
        pick_any = 1'b1;
        pick     = PW'(i);
      end
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      cur_v      <= 1'b0;
      cur_idx    <= '0;
      msg_vector <= '0;
      msg_mode   <= '0;
      msg_addr   <= '0;
    end else if (cur_v && msg_ack) begin
      cur_v <= 1'b0;
    end else if (!cur_v && pick_any) begin
      cur_v      <= 1'b1;
      cur_idx    <= pick;
      msg_vector <= vec_q[pick];
      msg_mode   <= mode_q[pick];
      msg_addr   <= {ADDR_TOP,
                     dmode_q[pick] ? dest_q[pick] : {4'b0, dest_q[pick][3:0]},
                     edid_q[pick], 1'b0, dmode_q[pick], 2'b0};
    end

  assign msg_valid = cur_v;

  p_valid_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (stat_q != '0));

  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  p_lock_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(stat_q) & ~stat_q) == '0) || $past(msg_valid && msg_ack)));

  p_hold_msg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_vector) &&
                                 $stable(msg_mode) && $stable(msg_addr)));

  p_ack_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ack) |=> !msg_valid);

  p_lowest_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |->
      (($past(stat_q) & ((NUM_PINS'(1) << cur_idx) - NUM_PINS'(1))) == '0));
endmodule

// File: tb/sim_irq_redirect_ctl.sv
`timescale 1ns/1ps
module sim_irq_redirect_ctl;
  localparam int N = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic         idx_we = 1'b0, data_we = 1'b0, ack = 1'b0;
  logic [7:0]   idx_wd = '0;
  logic [31:0]  data_wd = '0;
  logic [31:0]  rdata, maddr;
  logic         mvalid;
  logic [7:0]   mvec;
  logic [2:0]   mmode;

  irq_redirect_ctl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq),
    .idx_we(idx_we), .idx_wdata(idx_wd),
    .data_we(data_we), .data_wdata(data_wd), .data_rdata(rdata),
    .msg_valid(mvalid), .msg_vector(mvec), .msg_mode(mmode),
    .msg_addr(maddr), .msg_ack(ack)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] got_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  logic [7:0]   m_vec[N], m_dest[N], m_edid[N];
  logic [2:0]   m_mode[N];
  logic [N-1:0] m_dm, m_mask, m_st, m_irq_q;
  logic [7:0]   m_idx;
  bit           m_cv = 0;
  int           m_cur;
  logic [7:0]   m_ov;
  logic [2:0]   m_om;
  logic [31:0]  m_oa;

  function automatic logic [31:0] m_read();
    int o = int'(m_idx) - 16;
    int e;
    if (o < 0 || o >= 2 * N) return 32'h0;
    e = o / 2;
    if (o % 2 == 0)
      return {15'b0, m_mask[e], 3'b0, m_st[e], m_dm[e], m_mode[e], m_vec[e]};
    return {m_dest[e], m_edid[e], 1'b1, 15'b0};
  endfunction

  always @(posedge clk) begin : model
    int clr, lo, o, e;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vec[i] = 0; m_dest[i] = 0; m_edid[i] = 0; m_mode[i] = 0;
      end
      m_dm = '0; m_mask = '1; m_st = '0; m_irq_q = '0; m_idx = 0; m_cv = 0;
      m_cur = 0; m_ov = 0; m_om = 0; m_oa = 0;
    end else begin
      clr = -1;
      if (m_cv && ack) begin
        clr = m_cur;
        m_cv = 0;
      end else if (!m_cv) begin
        lo = -1;
        for (int i = N - 1; i >= 0; i--) if (m_st[i]) lo = i;
        if (lo >= 0) begin
          m_cv = 1; m_cur = lo; m_ov = m_vec[lo]; m_om = m_mode[lo];
          m_oa = {12'hFEE, m_dm[lo] ? m_dest[lo] : {4'h0, m_dest[lo][3:0]},
                  m_edid[lo], 1'b0, m_dm[lo], 2'b00};
        end
      end
      for (int i = 0; i < N; i++)
        if (i == clr) m_st[i] = 1'b0;
        else if (irq[i] && !m_irq_q[i] && !m_mask[i]) m_st[i] = 1'b1;
      o = int'(m_idx) - 16;
      if (data_we && o >= 0 && o < 2 * N) begin
        e = o / 2;
        if (o % 2 == 0) begin
          m_vec[e] = data_wd[7:0]; m_mode[e] = data_wd[10:8];
          m_dm[e] = data_wd[11]; m_mask[e] = data_wd[16];
        end else begin
          m_dest[e] = data_wd[31:24]; m_edid[e] = data_wd[23:16];
        end
      end
      if (idx_we) m_idx = idx_wd;
      m_irq_q = irq;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 rdata vs model", rdata, m_read());
    chk("R10 msg_valid vs model", 32'(mvalid), 32'(m_cv));
    if (m_cv) begin
      chk("R8 msg_vector vs model", 32'(mvec), 32'(m_ov));
      chk("R8 msg_mode vs model", 32'(mmode), 32'(m_om));
      chk("R9 msg_addr vs model", maddr, m_oa);
    end
    if (mvalid && ack) got_q.push_back(mvec);
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_idx(logic [7:0] a);
    idx_we = 1; idx_wd = a; step(); idx_we = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    set_idx(a);
    data_we = 1; data_wd = d; step(); data_we = 0;
  endtask

  task automatic ack_one(logic [N-1:0] also);
    int g = 0;
    while (!mvalid && g < 50) begin step(); g++; end
    ack = 1; irq = irq | also; step(); ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 msg_valid after reset", 32'(mvalid), 32'h0);
    set_idx(8'h10); chk("R1 entry0 low", rdata, 32'h0001_0000);
    set_idx(8'h11); chk("R1 entry0 high", rdata, 32'h0000_8000);

    // program: junk in reserved, status and delivery-type bits
    for (int p = 0; p < N; p++) begin
      wr(8'(16 + 2 * p), 32'hFFFE_F000 | ((p == 23) ? 32'h1_0000 : 32'h0) |
         (32'(p & 1) << 11) | (32'(p % 8) << 8) | 32'(8'h20 + p));
      wr(8'(17 + 2 * p), (32'(8'hA0 | p) << 24) | (32'(3 * p) << 16) | 32'h7FFF);
    end
    set_idx(8'h1A); chk("R3 entry5 low fields", rdata, 32'h0000_0D25);
    set_idx(8'h1B); chk("R4 entry5 high, type bit stays 1", rdata, 32'hA50F_8000);
    set_idx(8'h3E); chk("R3 entry23 low masked", rdata, 32'h0001_0F37);

    // R2 out-of-range
    wr(8'h40, 32'hFFFF_FFFF);
    chk("R2 index 40h reads 0", rdata, 32'h0);
    set_idx(8'h0F); chk("R2 index 0Fh reads 0", rdata, 32'h0);
    set_idx(8'h3F); chk("R2 entry23 high untouched", rdata, 32'hB745_8000);

    // pin 3 logical destination
    set_idx(8'h16);
    irq[3] = 1; step();
    chk("R5 status bit set", rdata, 32'h0000_1B23);
    chk("R5 not yet valid", 32'(mvalid), 32'h0);
    step();
    chk("R5 valid next cycle", 32'(mvalid), 32'h1);
    chk("R8 vector pin3", 32'(mvec), 32'h23);
    chk("R9 logical address", maddr, 32'hFEEA_3094);
    irq[3] = 0; step(); irq[3] = 1; step(); step();
    chk("R7 R8 still held", {23'b0, mvalid, mvec}, {23'b0, 1'b1, 8'h23});
    ack = 1; step(); ack = 0;
    chk("R10 valid dropped", 32'(mvalid), 32'h0);
    chk("R10 status cleared", rdata, 32'h0000_0B23);
    step(); step(); step();
    chk("R7 locked edge gave no message", 32'(mvalid), 32'h0);
    irq[3] = 0;

    // pin 2 physical destination
    irq[2] = 1; step(); step();
    chk("R9 physical address", maddr, 32'hFEE0_2060);
    ack_one('0); irq[2] = 0;

    // masked pin
    irq[23] = 1; step(); step(); step(); step();
    chk("R6 masked pin no message", 32'(mvalid), 32'h0);
    set_idx(8'h3E); chk("R6 masked status clear", rdata, 32'h0001_0F37);
    irq[23] = 0;

    // arbitration with an edge coinciding with acknowledge
    step(); step();
    got_q.delete();
    irq[5] = 1; irq[7] = 1; irq[9] = 1; step();
    irq[5] = 0; irq[7] = 0; irq[9] = 0; step();
    ack_one(24'h00_0022);
    ack_one('0); ack_one('0); ack_one('0);
    repeat (6) step();
    chk("R11 count of messages", 32'(got_q.size()), 32'd4);
    if (got_q.size() == 4) begin
      chk("R11 first pin5", 32'(got_q[0]), 32'h25);
      chk("R11 late pin1 overtakes", 32'(got_q[1]), 32'h21);
      chk("R11 then pin7", 32'(got_q[2]), 32'h27);
      chk("R7 pin5 edge at ack lost, pin9 last", 32'(got_q[3]), 32'h29);
    end
    irq[1] = 0; irq[5] = 0; step();
    irq[5] = 1; step(); step();
    chk("R10 pin5 re-armed", {23'b0, mvalid, mvec}, {23'b0, 1'b1, 8'h25});
    ack_one('0); irq[5] = 0;
    repeat (3) step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule